// File: doc/BRIEF.md
# Entropy Seed Collector with Repeat Test

This block takes raw bits from two independent noise streams, merges them into one stream, and packs that stream into 32-bit blocks. Every block goes through a continuous repeat test before it can be used. The test compares the block with the block that came just before it. If the two are equal, the block latches a failure that only reset clears.

A client asks for a seed with a one-cycle request pulse. The block then fills a 256-bit entropy field and a 128-bit nonce, in that order, from the next blocks that pass the test. When both fields are full it presents them for exactly one cycle, marked by a valid pulse. At every other time the seed buses read zero, so the collected material has no other way out of the block. Reset clears all stored material.

Top module: `entropy_seed_collector`

## Requirements
- R1: A mixed bit is produced only on a cycle where both `src_a_vld` and `src_b_vld` are high, and its value is `src_a_bit` XOR `src_b_bit`. A cycle where only one source is valid adds nothing to the stream.
- R2: Each group of 32 consecutive mixed bits forms one block. The first bit of the group lands in bit 0 of the block and the last bit lands in bit 31.
- R3: The first block completed after reset is kept only as the comparison reference and never appears in any seed.
- R4: Every later block is compared with the block before it. If they are equal, `rep_fail` goes high on the second rising edge after the edge that sampled the block's last bit.
- R5: Once high, `rep_fail` stays high until reset.
- R6: While `rep_fail` is high, `seed_valid` stays low, both seed buses are zero, and no block is used.
- R7: After a `req` pulse, the next 12 blocks that pass the test are collected. Passing block k (k = 0..7) goes to `seed_entropy[32k+31:32k]`, and passing block k = 8..11 goes to `seed_nonce[32(k-8)+31:32(k-8)]`.
- R8: `seed_valid` is a one-cycle pulse. It is asserted after the third rising edge following the edge that sampled the last bit of the 12th collected block. Completing a seed disarms the collector, so a further seed needs a new `req`. A `req` on the completing edge is ignored.
- R9: In every cycle where `seed_valid` is low, `seed_entropy` and `seed_nonce` are zero.
- R10: An active-low `rst_n` clears `rep_fail`, `seed_valid`, both buses and all partial collection.
- R11: Blocks that pass while no request is pending are thrown away. They still become the reference for the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| src_a_bit | input | 1 | Raw bit from noise source A |
| src_a_vld | input | 1 | Source A bit is valid |
| src_b_bit | input | 1 | Raw bit from noise source B |
| src_b_vld | input | 1 | Source B bit is valid |
| req | input | 1 | One-cycle request for a new seed |
| seed_entropy | output | 256 | Entropy field, nonzero only with seed_valid |
| seed_nonce | output | 128 | Nonce field, nonzero only with seed_valid |
| seed_valid | output | 1 | One-cycle seed presentation strobe |
| rep_fail | output | 1 | Sticky repeat-test failure |

## Verification
The embedded assertions check several properties on every cycle:
- a mixed bit appears only after a cycle where both sources were valid;
- a block completes only after a mixed bit;
- the first block never passes;
- every later block ends in either a pass or a failure;
- the failure never drops;
- the valid strobe never lasts two cycles or follows a failure.

Some properties are visible only at the ports over long scenarios, and the bench's cycle-accurate model and its directed scenarios cover them:
- the exact slot each block lands in;
- discarding blocks that pass while no request is pending;
- disarming after a seed;
- zeroing outputs during failure;
- recovery through reset.

// File: rtl/esc_pkg.sv
package esc_pkg;

  typedef enum logic [1:0] {
    BLK_REF    = 2'd0,
    BLK_PASS   = 2'd1,
    BLK_REPEAT = 2'd2
  } blk_verdict_e;

  function automatic logic mix_pair(input logic a, input logic b);
    return a ^ b;
  endfunction

  function automatic blk_verdict_e judge(input logic have_ref, input logic same);
    if (!have_ref) return BLK_REF;
    if (same)      return BLK_REPEAT;
    return BLK_PASS;
  endfunction

endpackage

// File: rtl/esc_mixer.sv
module esc_mixer
  import esc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_bit,
  input  logic a_vld,
  input  logic b_bit,
  input  logic b_vld,
  output logic mix_bit,
  output logic mix_vld
);

  logic both_vld;
  assign both_vld = a_vld & b_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_bit <= 1'b0;
      mix_vld <= 1'b0;
    end else begin
      mix_vld <= both_vld;
      if (both_vld) mix_bit <= mix_pair(a_bit, b_bit);
    end
  end

  AST_MIX_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    mix_vld |-> $past(a_vld && b_vld)); // R1

endmodule

// File: rtl/esc_packer.sv
module esc_packer #(
  parameter int BLK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mix_bit,
  input  logic             mix_vld,
  output logic [BLK_W-1:0] blk_data,
  output logic             blk_vld
);

  localparam int CW = $clog2(BLK_W);

  logic [BLK_W-1:0] sh_q;
  logic [CW-1:0]    cnt_q;
  logic [BLK_W-1:0] sh_next;
  logic             last_bit;

  assign sh_next  = {mix_bit, sh_q[BLK_W-1:1]};
  assign last_bit = mix_vld && (cnt_q == CW'(BLK_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      blk_data <= '0;
      blk_vld  <= 1'b0;
    end else begin
      blk_vld <= last_bit;
      if (mix_vld) begin
        sh_q  <= sh_next;
        cnt_q <= last_bit ? '0 : cnt_q + CW'(1);
      end
      if (last_bit) blk_data <= sh_next;
    end
  end

  AST_BLOCK_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_vld |-> $past(mix_vld)); // R2

endmodule

// File: rtl/esc_reptest.sv
module esc_reptest
  import esc_pkg::*;
#(
  parameter int BLK_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] blk_data,
  input  logic             blk_vld,
  output logic [BLK_W-1:0] ok_data,
  output logic             ok_vld,
  output logic             fail
);

  logic             have_ref;
  logic [BLK_W-1:0] ref_q;
  blk_verdict_e     verdict;

  assign verdict = judge(have_ref, blk_data == ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_ref <= 1'b0;
      ref_q    <= '0;
      fail     <= 1'b0;
      ok_vld   <= 1'b0;
      ok_data  <= '0;
    end else begin
      ok_vld <= 1'b0;
      if (blk_vld) begin
        unique case (verdict)
          BLK_REF: begin
            have_ref <= 1'b1;
            ref_q    <= blk_data;
          end
          BLK_REPEAT: fail <= 1'b1;
          BLK_PASS: begin
            ref_q <= blk_data;
            if (!fail) begin
              ok_vld  <= 1'b1;
              ok_data <= blk_data;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_FIRST_ONLY_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_vld && !have_ref) |=> !ok_vld); // R3
  AST_EVERY_BLOCK_JUDGED: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_vld && have_ref) |=> (ok_vld || fail)); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail); // R5

endmodule

// File: rtl/esc_assembler.sv
module esc_assembler #(
  parameter int BLK_W   = 32,
  parameter int ENT_W   = 256,
  parameter int NONCE_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               ok_vld,
  input  logic [BLK_W-1:0]   ok_data,
  input  logic               fail,
  output logic               done_q,
  output logic [ENT_W-1:0]   ent,
  output logic [NONCE_W-1:0] nonce
);

  localparam int TOT_W = ENT_W + NONCE_W;
  localparam int NBLK  = TOT_W / BLK_W;
  localparam int IW    = $clog2(NBLK + 1);

  logic [IW-1:0]    idx_q;
  logic             armed_q;
  logic             take;
  logic             finish;
  logic [TOT_W-1:0] flat;

  assign take   = ok_vld && armed_q && !fail;
  assign finish = take && (idx_q == IW'(NBLK-1));

  for (genvar k = 0; k < NBLK; k++) begin : g_slot
    logic [BLK_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q <= '0;
      else if (take && idx_q == IW'(k))    word_q <= ok_data;
    end
    assign flat[k*BLK_W +: BLK_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) begin
        idx_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        if (take) idx_q <= idx_q + IW'(1);
        if (req)  armed_q <= 1'b1;
      end
    end
  end

  assign ent   = flat[ENT_W-1:0];
  assign nonce = flat[TOT_W-1:ENT_W];

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_FAIL_BLOCKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !done_q); // R6

endmodule

// File: rtl/entropy_seed_collector.sv
module entropy_seed_collector #(
  parameter int BLK_W   = 32,
  parameter int ENT_W   = 256,
  parameter int NONCE_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_a_bit,
  input  logic               src_a_vld,
  input  logic               src_b_bit,
  input  logic               src_b_vld,
  input  logic               req,
  output logic [ENT_W-1:0]   seed_entropy,
  output logic [NONCE_W-1:0] seed_nonce,
  output logic               seed_valid,
  output logic               rep_fail
);

  logic             mix_bit, mix_vld;
  logic [BLK_W-1:0] blk_data, ok_data;
  logic             blk_vld, ok_vld, fail_w, done_w;
  logic [ENT_W-1:0]   ent_w;
  logic [NONCE_W-1:0] nonce_w;

  esc_mixer u_mix (
    .clk(clk), .rst_n(rst_n),
    .a_bit(src_a_bit), .a_vld(src_a_vld),
    .b_bit(src_b_bit), .b_vld(src_b_vld),
    .mix_bit(mix_bit), .mix_vld(mix_vld)
  );

  esc_packer #(.BLK_W(BLK_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .mix_bit(mix_bit), .mix_vld(mix_vld),
    .blk_data(blk_data), .blk_vld(blk_vld)
  );

  esc_reptest #(.BLK_W(BLK_W)) u_rep (
    .clk(clk), .rst_n(rst_n),
    .blk_data(blk_data), .blk_vld(blk_vld),
    .ok_data(ok_data), .ok_vld(ok_vld), .fail(fail_w)
  );

  esc_assembler #(.BLK_W(BLK_W), .ENT_W(ENT_W), .NONCE_W(NONCE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .req(req),
    .ok_vld(ok_vld), .ok_data(ok_data), .fail(fail_w),
    .done_q(done_w), .ent(ent_w), .nonce(nonce_w)
  );

  assign seed_valid   = done_w && !fail_w;
  assign seed_entropy = seed_valid ? ent_w : '0;
  assign seed_nonce   = seed_valid ? nonce_w : '0;
  assign rep_fail     = fail_w;

endmodule

// File: tb/sim_entropy_seed_collector.sv
module sim_entropy_seed_collector;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_bit = 1'b0, a_vld = 1'b0, b_bit = 1'b0, b_vld = 1'b0, req = 1'b0;
  logic [255:0] seed_entropy;
  logic [127:0] seed_nonce;
  logic seed_valid, rep_fail;

  always #2ns clk = ~clk;

  entropy_seed_collector u0 (
    .clk(clk), .rst_n(rst_n),
    .src_a_bit(a_bit), .src_a_vld(a_vld),
    .src_b_bit(b_bit), .src_b_vld(b_vld),
    .req(req), .seed_entropy(seed_entropy), .seed_nonce(seed_nonce),
    .seed_valid(seed_valid), .rep_fail(rep_fail)
  );

  int total = 0, bad = 0, seeds_seen = 0;
  logic [255:0] cap_ent;
  logic [127:0] cap_non;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_word, m_ref;
  int          m_cnt;
  bit          m_have, m_dfail, m_fail, m_arm, m_valid;
  bit          pend_v[3];
  logic [31:0] pend_d[3];
  bit          fpend[2];
  logic [31:0] m_slots[12];
  int          m_idx;
  logic [255:0] m_ent;
  logic [127:0] m_non;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word = '0; m_ref = '0; m_cnt = 0; m_have = 0; m_dfail = 0; m_fail = 0;
      m_arm = 0; m_valid = 0; m_idx = 0; m_ent = '0; m_non = '0;
      for (int i = 0; i < 3; i++) begin pend_v[i] = 0; pend_d[i] = '0; end
      fpend[0] = 0; fpend[1] = 0;
    end else begin
      bit cons, completing;
      logic [31:0] cdata;
      cons = pend_v[0]; cdata = pend_d[0];
      pend_v[0] = pend_v[1]; pend_d[0] = pend_d[1];
      pend_v[1] = pend_v[2]; pend_d[1] = pend_d[2];
      pend_v[2] = 0;
      if (fpend[0]) m_fail = 1;
      fpend[0] = fpend[1]; fpend[1] = 0;
      if (a_vld && b_vld) begin
        m_word[m_cnt] = a_bit ^ b_bit;
        m_cnt++;
        if (m_cnt == 32) begin
          m_cnt = 0;
          if (!m_have) begin m_have = 1; m_ref = m_word; end
          else if (m_word == m_ref) begin
            if (!m_dfail) fpend[1] = 1;
            m_dfail = 1;
          end else begin
            if (!m_dfail) begin pend_v[2] = 1; pend_d[2] = m_word; end
            m_ref = m_word;
          end
        end
      end
      m_valid = 0; completing = 0;
      if (cons && m_arm && !m_fail) begin
        m_slots[m_idx] = cdata;
        m_idx++;
        if (m_idx == 12) begin
          for (int k = 0; k < 8; k++) m_ent[32*k +: 32] = m_slots[k];
          for (int k = 0; k < 4; k++) m_non[32*k +: 32] = m_slots[8+k];
          m_valid = 1; m_idx = 0; m_arm = 0; completing = 1;
        end
      end
      if (!completing && req) m_arm = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit ev;
      ev = m_valid && !m_fail;
      chk(seed_valid == ev, "R8 seed_valid", {255'd0, seed_valid}, {255'd0, ev});
      chk(rep_fail == m_fail, "R5 rep_fail", {255'd0, rep_fail}, {255'd0, m_fail});
      if (ev) begin
        chk(seed_entropy == m_ent, "R7 entropy", seed_entropy, m_ent);
        chk(seed_nonce == m_non, "R7 nonce", {128'd0, seed_nonce}, {128'd0, m_non});
      end else begin
        chk(seed_entropy == '0 && seed_nonce == '0, "R9 quiet buses",
            seed_entropy | {128'd0, seed_nonce}, '0);
      end
      if (seed_valid) begin
        seeds_seen++;
        cap_ent = seed_entropy;
        cap_non = seed_nonce;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] bv(input int i);
    return 32'h6A09E667 ^ (i * 32'h9E3779B1);
  endfunction

  task automatic send_blk(input logic [31:0] comb, input bit noisy);
    for (int i = 0; i < 32; i++) begin
      logic bb;
      bb = (comb[(i+7)%32] ^ i[0]);
      if (noisy && (i % 5 == 0)) begin
        @(negedge clk);
        a_vld = (i % 10 == 0); b_vld = !a_vld;
        a_bit = 1'b1; b_bit = 1'b1;
      end
      @(negedge clk);
      a_vld = 1'b1; b_vld = 1'b1;
      b_bit = bb; a_bit = comb[i] ^ bb;
    end
    @(negedge clk);
    a_vld = 1'b0; b_vld = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // ---------------- scenarios ----------------
  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(seed_valid == 0 && rep_fail == 0 && seed_entropy == '0 && seed_nonce == '0,
        "R10 reset state", {254'd0, seed_valid, rep_fail}, '0);
    rst_n = 1'b1;

    // R3 + R2: first block only reference
    pulse_req();
    for (int i = 0; i < 13; i++) send_blk(bv(i), 1'b0);
    settle();
    chk(seeds_seen == 1, "R7 one seed", seeds_seen, 1);
    chk(cap_ent[31:0] == bv(1), "R3 first block skipped", {224'd0, cap_ent[31:0]}, {224'd0, bv(1)});
    chk(cap_ent[255:224] == bv(8), "R2 entropy top slot", {224'd0, cap_ent[255:224]}, {224'd0, bv(8)});
    chk(cap_non[127:96] == bv(12), "R7 nonce top slot", {224'd0, cap_non[127:96]}, {224'd0, bv(12)});

    // R8: disarmed after seed; R11: blocks without request discarded
    for (int i = 20; i < 33; i++) send_blk(bv(i), 1'b0);
    settle();
    chk(seeds_seen == 1, "R11 no seed without req", seeds_seen, 1);

    // R1: one-sided cycles ignored
    pulse_req();
    for (int i = 40; i < 52; i++) send_blk(bv(i), 1'b1);
    settle();
    chk(seeds_seen == 2, "R1 seed with noisy sources", seeds_seen, 2);
    chk(cap_ent[31:0] == bv(40), "R1 mixed word", {224'd0, cap_ent[31:0]}, {224'd0, bv(40)});
    chk(cap_non[31:0] == bv(48), "R7 nonce low slot", {224'd0, cap_non[31:0]}, {224'd0, bv(48)});

    // R4: repeated block trips failure
    pulse_req();
    send_blk(bv(60), 1'b0);
    send_blk(bv(61), 1'b0);
    chk(rep_fail == 0, "R4 distinct blocks pass", {255'd0, rep_fail}, '0);
    send_blk(bv(61), 1'b0);
    settle();
    chk(rep_fail == 1, "R4 repeat detected", {255'd0, rep_fail}, 1);

    // R5, R6: failure holds and blocks seeds
    base = seeds_seen;
    pulse_req();
    for (int i = 70; i < 84; i++) send_blk(bv(i), 1'b0);
    settle();
    chk(rep_fail == 1, "R5 fail sticky", {255'd0, rep_fail}, 1);
    chk(seeds_seen == base, "R6 no seed while failed", seeds_seen, base);
    chk(seed_entropy == '0 && seed_nonce == '0, "R6 buses zero", seed_entropy, '0);

    // R10: reset recovers; reference restarts
    do_reset();
    @(negedge clk);
    chk(rep_fail == 0, "R10 fail cleared", {255'd0, rep_fail}, '0);
    pulse_req();
    send_blk(bv(90), 1'b0);
    send_blk(bv(90) ^ 32'h1, 1'b0);
    for (int i = 91; i < 102; i++) send_blk(bv(i), 1'b0);
    settle();
    chk(seeds_seen == base + 1, "R10 seed after recovery", seeds_seen, base + 1);
    chk(cap_ent[31:0] == (bv(90) ^ 32'h1), "R3 reference after reset",
        {224'd0, cap_ent[31:0]}, {224'd0, bv(90) ^ 32'h1});

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      total++; bad++;
      $display("FAIL watchdog R8 act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule